// File: doc/BRIEF.md
# Shift-Register Program Sequencer

This block generates the program-ROM address for a small 4-bit controller. A 4-bit page register and a 6-bit program counter together form a 10-bit ROM address. The counter does not count in binary. Each advance moves it one step along a maximal-length feedback-shift-register sequence, so consecutive instructions sit at scattered offsets within a page. A linear program still visits every offset of the page except one.

Control transfers use a 4-bit page buffer and a 6-bit return register rather than a memory stack. Software preloads the destination page into the buffer, and a branch then jumps to that page. A call swaps the page register with the buffer and saves the return point. A return swaps them back. This gives exactly one level of subroutine. While inside a subroutine, a branch can only move within the current page, and a nested call is refused. Every command completes in a single clock cycle, and the block has no interrupt path.

Top module: `prog_seq`

## Requirements
- R1: While rst_ni is low, and after it rises, the page register, program counter and page buffer are all zero and the subroutine flag is clear.
- R2: rom_addr_o is the page register in bits [9:6] concatenated with the program counter in bits [5:0].
- R3: An advance replaces the counter pc with {pc[4:0], ~(pc[5] ^ pc[4])} and leaves the page unchanged.
- R4: An advance from counter value 6'h3F yields 6'h00. Starting from 6'h00, the counter first returns to 6'h00 after exactly 63 advances and never takes the value 6'h3F on the way.
- R5: A page-buffer load writes target_i[3:0] into the page buffer and leaves rom_addr_o unchanged.
- R6: A branch outside a subroutine loads the counter from target_i and the page register from the page buffer.
- R7: A call outside a subroutine does four things: it saves the advanced counter (per R3/R4) as the return point, loads the counter from target_i, exchanges the page register with the page buffer, and sets the subroutine flag.
- R8: A return inside a subroutine does three things: it loads the counter from the return point, exchanges the page register with the page buffer again, and clears the subroutine flag.
- R9: A branch inside a subroutine loads the counter from target_i and leaves the page register unchanged.
- R10: A call inside a subroutine, or a return outside one, has no effect on any state.
- R11: When several command inputs are high together, only the highest-priority command executes, in the order return > call > branch > page-buffer load > advance. With no command, all state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Step the counter to its next sequence value |
| branch_i | input | 1 | Jump to target_i (page from the page buffer when outside a subroutine) |
| call_i | input | 1 | Enter a subroutine at target_i |
| ret_i | input | 1 | Leave the subroutine |
| pb_load_i | input | 1 | Load the page buffer from target_i[3:0] |
| target_i | input | 6 | Jump/call destination offset, or page-buffer value |
| rom_addr_o | output | 10 | Program ROM address {page, counter} |

## Verification
The bound checker checks the following on every cycle: the counter step and the lock-up escape, that page-buffer loads and refused calls or returns leave the address still, the page source of branches inside and outside a subroutine, and the entry to and exit from the subroutine flag. Some behaviour can only be shown by the bench's scenarios. This includes the full 63-step period of the counter and the return to the exact saved point with the original page. It also includes the clearing of the page buffer and subroutine flag by a reset taken in the middle of a call. The priority resolution when several commands are high in the same cycle is likewise covered by the scenarios.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ADV  = 3'd1,
    CMD_PB   = 3'd2,
    CMD_BR   = 3'd3,
    CMD_CALL = 3'd4,
    CMD_RET  = 3'd5
  } seq_cmd_e;

endpackage

// File: rtl/prog_seq_cmd_arb.sv
module prog_seq_cmd_arb
  import prog_seq_pkg::*;
(
  input  logic     adv_i,
  input  logic     branch_i,
  input  logic     call_i,
  input  logic     ret_i,
  input  logic     pb_load_i,
  output seq_cmd_e cmd_o
);

  always_comb begin
    if (ret_i)          cmd_o = CMD_RET;
    else if (call_i)    cmd_o = CMD_CALL;
    else if (branch_i)  cmd_o = CMD_BR;
    else if (pb_load_i) cmd_o = CMD_PB;
    else if (adv_i)     cmd_o = CMD_ADV;
    else                cmd_o = CMD_NONE;
  end

endmodule

// File: rtl/prog_seq_lfsr_step.sv
module prog_seq_lfsr_step #(
  parameter int unsigned W      = 6,
  parameter int unsigned TAP_HI = 5,
  parameter int unsigned TAP_LO = 4
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);

  localparam logic [W-1:0] LOCKUP = {W{1'b1}};

  logic         fb;
  logic [W-1:0] shifted;

  // XNOR feedback: all-zero is a legal state, all-ones is the dead state
  assign fb = ~(cur_i[TAP_HI] ^ cur_i[TAP_LO]);

  assign shifted[0] = fb;
  for (genvar b = 1; b < W; b++) begin : g_shift
    assign shifted[b] = cur_i[b-1];
  end

  assign nxt_o = (cur_i == LOCKUP) ? '0 : shifted;

endmodule

// File: rtl/prog_seq_sub_ctrl.sv
module prog_seq_sub_ctrl
  import prog_seq_pkg::*;
#(
  parameter int unsigned PC_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  seq_cmd_e        cmd_i,
  input  logic [PC_W-1:0] ret_pt_i,
  output logic            in_sub_o,
  output logic            call_take_o,
  output logic            ret_take_o,
  output logic [PC_W-1:0] ret_addr_o
);

  logic            in_sub_q;
  logic [PC_W-1:0] ret_q;

  assign call_take_o = (cmd_i == CMD_CALL) && !in_sub_q;
  assign ret_take_o  = (cmd_i == CMD_RET)  &&  in_sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sub_q <= 1'b0;
      ret_q    <= '0;
    end else if (call_take_o) begin
      in_sub_q <= 1'b1;
      ret_q    <= ret_pt_i;
    end else if (ret_take_o) begin
      in_sub_q <= 1'b0;
    end
  end

  assign in_sub_o   = in_sub_q;
  assign ret_addr_o = ret_q;

endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int unsigned PC_W   = 6,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned TAP_HI = 5,
  parameter int unsigned TAP_LO = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   adv_i,
  input  logic                   branch_i,
  input  logic                   call_i,
  input  logic                   ret_i,
  input  logic                   pb_load_i,
  input  logic [PC_W-1:0]        target_i,
  output logic [PAGE_W+PC_W-1:0] rom_addr_o
);

  seq_cmd_e          cmd;
  logic [PC_W-1:0]   pc_q, pc_d, pc_adv, ret_addr;
  logic [PAGE_W-1:0] page_q, page_d, pb_q, pb_d;
  logic              in_sub_q, call_take, ret_take;

  prog_seq_cmd_arb u_arb (
    .adv_i     (adv_i),
    .branch_i  (branch_i),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .pb_load_i (pb_load_i),
    .cmd_o     (cmd)
  );

  prog_seq_lfsr_step #(
    .W      (PC_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO)
  ) u_step (
    .cur_i (pc_q),
    .nxt_o (pc_adv)
  );

  prog_seq_sub_ctrl #(
    .PC_W (PC_W)
  ) u_sub (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .ret_pt_i    (pc_adv),
    .in_sub_o    (in_sub_q),
    .call_take_o (call_take),
    .ret_take_o  (ret_take),
    .ret_addr_o  (ret_addr)
  );

  always_comb begin
    pc_d   = pc_q;
    page_d = page_q;
    pb_d   = pb_q;
    unique case (cmd)
      CMD_ADV: pc_d = pc_adv;
      CMD_PB:  pb_d = target_i[PAGE_W-1:0];
      CMD_BR: begin
        pc_d = target_i;
        if (!in_sub_q) page_d = pb_q;
      end
      CMD_CALL: if (call_take) begin
        pc_d   = target_i;
        page_d = pb_q;
        pb_d   = page_q;
      end
      CMD_RET: if (ret_take) begin
        pc_d   = ret_addr;
        page_d = pb_q;
        pb_d   = page_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      page_q <= '0;
      pb_q   <= '0;
    end else begin
      pc_q   <= pc_d;
      page_q <= page_d;
      pb_q   <= pb_d;
    end
  end

  assign rom_addr_o = {page_q, pc_q};

endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int unsigned PC_W   = 6,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned TAP_HI = 5,
  parameter int unsigned TAP_LO = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   adv_i,
  input logic                   branch_i,
  input logic                   call_i,
  input logic                   ret_i,
  input logic                   pb_load_i,
  input logic [PC_W-1:0]        target_i,
  input logic [PAGE_W+PC_W-1:0] rom_addr_o,
  input logic                   in_sub_i,
  input logic [PAGE_W-1:0]      pb_i
);

  logic [PC_W-1:0]   pc;
  logic [PAGE_W-1:0] page;
  logic do_ret, do_call, do_br, do_pb, do_adv, idle;

  assign pc      = rom_addr_o[PC_W-1:0];
  assign page    = rom_addr_o[PAGE_W+PC_W-1:PC_W];
  assign do_ret  = ret_i;
  assign do_call = call_i && !ret_i;
  assign do_br   = branch_i && !call_i && !ret_i;
  assign do_pb   = pb_load_i && !branch_i && !call_i && !ret_i;
  assign do_adv  = adv_i && !pb_load_i && !branch_i && !call_i && !ret_i;
  assign idle    = !(adv_i || pb_load_i || branch_i || call_i || ret_i);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (rom_addr_o == '0);
  end

  assert_adv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_adv && (pc != {PC_W{1'b1}}) |=>
      pc == {$past(pc[PC_W-2:0]), ~($past(pc[TAP_HI]) ^ $past(pc[TAP_LO]))} && $stable(page));

  assert_lockup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_adv && (pc == {PC_W{1'b1}}) |=> pc == '0);

  assert_pb_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pb |=> $stable(rom_addr_o));

  assert_branch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_br && !in_sub_i |=> pc == $past(target_i) && page == $past(pb_i));

  assert_call_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_call && !in_sub_i |=> in_sub_i && pc == $past(target_i) && page == $past(pb_i));

  assert_ret_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_ret && in_sub_i |=> !in_sub_i && page == $past(pb_i));

  assert_branch_sub_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_br && in_sub_i |=> pc == $past(target_i) && $stable(page));

  assert_refused_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_call && in_sub_i) || (do_ret && !in_sub_i) |=> $stable(rom_addr_o) && $stable(in_sub_i));

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(rom_addr_o) && $stable(in_sub_i));

endmodule

bind prog_seq prog_seq_chk #(
  .PC_W   (PC_W),
  .PAGE_W (PAGE_W),
  .TAP_HI (TAP_HI),
  .TAP_LO (TAP_LO)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adv_i      (adv_i),
  .branch_i   (branch_i),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .pb_load_i  (pb_load_i),
  .target_i   (target_i),
  .rom_addr_o (rom_addr_o),
  .in_sub_i   (in_sub_q),
  .pb_i       (pb_q)
);

// File: tb/prog_seq_test.sv
module prog_seq_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 18;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       adv_i = 1'b0, branch_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, pb_load_i = 1'b0;
  logic [5:0] target_i = '0;
  logic [9:0] rom_addr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prog_seq uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv_i),
    .branch_i   (branch_i),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .pb_load_i  (pb_load_i),
    .target_i   (target_i),
    .rom_addr_o (rom_addr_o)
  );

  // {adv, branch, call, ret, pb_load} , target , expected rom_addr after the edge
  localparam logic [20:0] VEC [NVEC] = '{
    {5'b10000, 6'h00, 10'h001},  // R3
    {5'b10000, 6'h00, 10'h003},  // R3
    {5'b00001, 6'h05, 10'h003},  // R5 pb=5
    {5'b10000, 6'h00, 10'h007},  // R3
    {5'b01000, 6'h10, 10'h150},  // R6 page<-5
    {5'b00001, 6'h0A, 10'h150},  // R5 pb=A
    {5'b00100, 6'h20, 10'h2A0},  // R7 ret pt 20, pb<-5
    {5'b10000, 6'h00, 10'h280},  // R3 20->00
    {5'b01000, 6'h3F, 10'h2BF},  // R9 page kept
    {5'b10000, 6'h00, 10'h280},  // R4 3F->00
    {5'b00100, 6'h11, 10'h280},  // R10 nested call refused
    {5'b00010, 6'h00, 10'h160},  // R8 back to page 5, pc 20
    {5'b00010, 6'h00, 10'h160},  // R10 return outside refused
    {5'b01000, 6'h01, 10'h281},  // R6 page<-A
    {5'b11000, 6'h02, 10'h282},  // R11 branch over advance
    {5'b10001, 6'h03, 10'h282},  // R11 pb load over advance
    {5'b10000, 6'h00, 10'h285},  // R3 02->05
    {5'b00000, 6'h00, 10'h285}   // R11 idle holds
  };

  localparam int VREQ [NVEC] = '{3,3,5,3,6,5,7,3,9,4,10,8,10,6,11,11,3,11};

  task automatic check(input int req, input logic [9:0] exp);
    n_chk++;
    if (rom_addr_o !== exp) begin
      n_fail++;
      $display("FAIL R%0d: rom_addr_o=%h expected %h", req, rom_addr_o, exp);
    end
  endtask

  task automatic apply(input logic [4:0] c, input logic [5:0] t);
    {adv_i, branch_i, call_i, ret_i, pb_load_i} = c;
    target_i = t;
    @(posedge clk_i);
    @(negedge clk_i);
    {adv_i, branch_i, call_i, ret_i, pb_load_i} = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    check(1, 10'h000);  // R1 asynchronous clear
    @(negedge clk_i);
    @(negedge clk_i);
    check(1, 10'h000);  // R1 held
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    do_reset();

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][20:16], VEC[i][15:10]);
      check(VREQ[i], VEC[i][9:0]);
    end

    // R4: full period from zero
    do_reset();
    begin
      int first_zero = 0;
      int saw_ones   = 0;
      for (int i = 1; i <= 70; i++) begin
        apply(5'b10000, 6'h00);
        if (rom_addr_o[5:0] == 6'h3F) saw_ones++;
        if (rom_addr_o[5:0] == 6'h00 && first_zero == 0) first_zero = i;
      end
      n_chk++;
      if (first_zero != 63) begin
        n_fail++;
        $display("FAIL R4: period=%0d expected 63", first_zero);
      end
      n_chk++;
      if (saw_ones != 0) begin
        n_fail++;
        $display("FAIL R4: all-ones visits=%0d expected 0", saw_ones);
      end
    end

    // R1: reset in the middle of a subroutine
    do_reset();
    apply(5'b00001, 6'h07);
    apply(5'b00100, 6'h09);
    check(7, 10'h1C9);          // R7 page<-7, pc 09
    do_reset();
    apply(5'b01000, 6'h04);
    check(1, 10'h004);          // R1 buffer cleared, flag cleared
    apply(5'b00010, 6'h00);
    check(10, 10'h004);         // R10 return refused after reset
    apply(5'b00000, 6'h2A);
    check(2, 10'h004);          // R2 target ignored when idle

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule